// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a two-wire serial protocol engine and the storage array of an 8K x 8 byte memory. A write transfer first loads a starting word address and then delivers data bytes one strobe at a time. The block collects these bytes in a 32-entry page buffer. The upper address bits pick the page and stay fixed for the whole transfer. The five low bits walk through the page and wrap inside it.

When the protocol engine reports a stop condition after at least one data byte, the block raises a busy flag for a self-timed write cycle. The length of that cycle, counted in system clocks, comes from a programmable input. During the first 32 clocks of the cycle the block sweeps the buffer in ascending slot order. It issues one array write for each slot that took data in this transfer and is not write-protected. While busy, the block ignores loads, bytes and stops.

Write protection follows a protect pin and a mode bit. With the pin low, no address is protected. With the pin high, mode 0 protects every address and mode 1 protects only the top quarter of the array. The protocol engine still acknowledges a protected byte and the pointer still advances past it, but the byte never reaches the array.

Top module: `pwb_commit`

## Requirements
- R1: After reset, `busy` and `arr_we` are 0 and `ptr_addr` is 0.
- R2: A byte strobe stores `byte_data` at the pointer `ptr_addr` and adds one to its five low bits only. Its upper eight bits (the page) keep the value loaded by `addr_load`, and every array write goes to that page.
- R3: A byte taken at slot 31 is followed by slot 0 of the same page. With more than 32 bytes in one transfer, each slot keeps the last byte sent to it.
- R4: A stop strobe raises `busy` only when at least one byte strobe was taken since the last `addr_load` or the last commit. Otherwise it has no effect.
- R5: `busy` rises on the clock edge that samples a qualifying stop. It stays high for exactly max(`cycle_len`, 32) clocks, using the `cycle_len` value sampled at that edge.
- R6: In busy clock k (k = 0..31), `arr_we` is 1 exactly when slot k took an unprotected byte in this transfer. In that clock `arr_addr` = {page, k} and `arr_wdata` is the last byte stored in slot k. Writes therefore come in ascending slot order, at most once per slot.
- R7: While `busy` is 1, `addr_load`, `byte_stb` and `stop_stb` have no effect: `ptr_addr` does not change, the ignored bytes are never written, and the ignored stop does not start another cycle.
- R8: An address is protected when `wp` is 1 and either `prot_mode` is 0 or the two top address bits are 11 (addresses 1800h to 1FFFh). A byte taken at a protected address advances the pointer and counts for R4, but it is not written to the array.
- R9: When a cycle ends, every slot is marked empty. A later transfer writes only the slots it fills itself.
- R10: After the cycle ends, `ptr_addr` holds the address after the last byte taken, wrapped within the page.
- R11: When `addr_load` and `byte_stb` arrive together, the load wins and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_len | input | 20 | Write cycle length in clocks (values below 32 act as 32) |
| prot_mode | input | 1 | 0: protect whole array, 1: protect top quarter only |
| wp | input | 1 | Write-protect enable |
| addr_load | input | 1 | Strobe: start a transfer at `start_addr` |
| start_addr | input | 13 | Starting word address |
| byte_stb | input | 1 | Strobe: one data byte received |
| byte_data | input | 8 | Data byte |
| stop_stb | input | 1 | Strobe: stop condition seen |
| busy | output | 1 | Write cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 13 | Array write address |
| arr_wdata | output | 8 | Array write data |
| ptr_addr | output | 13 | Current word address pointer |

## Verification
The hardest case to reach is a transfer longer than a page that starts close to the page end. Only such a transfer shows wrap-around and overwrite of earlier slots together. The stimulus starts 34 bytes at slot 30, so the first two slots are rewritten after a full lap, and then checks all 32 array locations. A second hard case is stimulus during a running cycle. Bytes, a load and a stop are injected while `busy` is high, and the bench then checks that the pointer, the array image and the cycle count show no trace of them. Protection is exercised on both sides of the top-quarter boundary within one page that straddles no boundary, and on a page above it.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic {
        PROT_WHOLE   = 1'b0,
        PROT_TOP_QTR = 1'b1
    } prot_mode_e;

endpackage

// File: rtl/pwb_prot.sv
module pwb_prot
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp,
    input  prot_mode_e        mode,
    output logic              locked
);

    logic in_top_qtr;

    always_comb begin
        in_top_qtr = (addr[ADDR_W-1 -: 2] == 2'b11);
        locked     = wp && ((mode == PROT_WHOLE) || in_top_qtr);
    end

endmodule

// File: rtl/pwb_slots.sv
module pwb_slots #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_keep,
    input  logic              clr,
    input  logic [OFS_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_q [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        slot_t slot_d;
        logic  hit;

        always_comb begin
            hit    = wr_en && (wr_idx == OFS_W'(g));
            slot_d = slot_q[g];
            if (clr) begin
                slot_d.full = 1'b0;
            end else if (hit) begin
                slot_d.full = wr_keep;
                slot_d.data = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d;
            end
        end
    end

    always_comb begin
        rd_valid = slot_q[rd_idx].full;
        rd_data  = slot_q[rd_idx].data;
    end

endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int CNT_W      = 20,
    parameter int PAGE_BYTES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [CNT_W-1:0] cycle_len,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        last  = tmr_q.busy && (tmr_q.cnt == tmr_q.len - CNT_W'(1));
        if (tmr_q.busy) begin
            if (last) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
            end
        end else if (launch) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = '0;
            tmr_d.len  = (cycle_len < MIN_LEN) ? MIN_LEN : cycle_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = tmr_q.busy;
    assign cnt  = tmr_q.cnt;

endmodule

// File: rtl/pwb_commit.sv
module pwb_commit
    import pwb_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int CNT_W      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cycle_len,
    input  logic              prot_mode,
    input  logic              wp,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_stb,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [ADDR_W-1:0] ptr_addr
);

    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ofs;
        logic              got;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              slot_we;
    logic              slot_clr;
    logic              launch;
    logic              byte_locked;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0]  cyc_cnt;
    logic              cyc_last;
    logic              sweep_on;
    logic [OFS_W-1:0]  sweep_idx;

    // Next-state logic for the pointer and transfer flag
    always_comb begin
        ctl_d    = ctl_q;
        slot_we  = 1'b0;
        slot_clr = 1'b0;
        launch   = 1'b0;
        if (cyc_last) begin
            slot_clr  = 1'b1;
            ctl_d.got = 1'b0;
        end
        if (!busy) begin
            if (addr_load) begin
                {ctl_d.page, ctl_d.ofs} = start_addr;
                ctl_d.got = 1'b0;
                slot_clr  = 1'b1;
            end else if (byte_stb) begin
                slot_we   = 1'b1;
                ctl_d.ofs = ctl_q.ofs + OFS_W'(1);
                ctl_d.got = 1'b1;
            end
            launch = stop_stb && ctl_q.got;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pwb_prot #(
        .ADDR_W (ADDR_W)
    ) u_prot (
        .addr   ({ctl_q.page, ctl_q.ofs}),
        .wp     (wp),
        .mode   (prot_mode_e'(prot_mode)),
        .locked (byte_locked)
    );

    pwb_slots #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (slot_we),
        .wr_idx   (ctl_q.ofs),
        .wr_data  (byte_data),
        .wr_keep  (!byte_locked),
        .clr      (slot_clr),
        .rd_idx   (sweep_idx),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    pwb_timer #(
        .CNT_W      (CNT_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .cycle_len (cycle_len),
        .busy      (busy),
        .cnt       (cyc_cnt),
        .last      (cyc_last)
    );

    always_comb begin
        sweep_on  = busy && (cyc_cnt < CNT_W'(PAGE_BYTES));
        sweep_idx = cyc_cnt[OFS_W-1:0];
        arr_we    = sweep_on && rd_valid;
        arr_addr  = {ctl_q.page, sweep_idx};
        arr_wdata = rd_data;
        ptr_addr  = {ctl_q.page, ctl_q.ofs};
    end

endmodule

// File: rtl/pwb_commit_chk.sv
module pwb_commit_chk #(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_stb,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [ADDR_W-1:0] ptr_addr
);

    localparam int OFS_W = $clog2(PAGE_BYTES);

    int unsigned      run_q;
    logic             seen_q;
    logic [OFS_W-1:0] last_ofs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= 0;
            seen_q     <= 1'b0;
            last_ofs_q <= '0;
        end else begin
            run_q <= busy ? run_q + 1 : 0;
            if (!busy) begin
                seen_q <= 1'b0;
            end else if (arr_we) begin
                seen_q     <= 1'b1;
                last_ofs_q <= arr_addr[OFS_W-1:0];
            end
        end
    end

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R6

    AST_WE_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_addr[ADDR_W-1:OFS_W] == ptr_addr[ADDR_W-1:OFS_W])); // R2

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_stb)); // R5

    AST_MIN_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q >= PAGE_BYTES)); // R5

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ptr_addr)); // R7

    AST_WE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && seen_q) |-> (arr_addr[OFS_W-1:0] > last_ofs_q)); // R6

endmodule

bind pwb_commit pwb_commit_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_stb (stop_stb),
    .busy     (busy),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .ptr_addr (ptr_addr)
);

// File: tb/pwb_commit_tb.sv
module pwb_commit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cycle_len = 20'd40;
    logic        prot_mode = 1'b0;
    logic        wp = 1'b0;
    logic        addr_load = 1'b0;
    logic [12:0] start_addr = '0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_stb = 1'b0;
    logic        busy;
    logic        arr_we;
    logic [12:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic [12:0] ptr_addr;

    int checks = 0;
    int errors = 0;
    int total_w = 0;
    int cyc = 0;

    logic [7:0] img  [0:8191];
    int         wcnt [0:8191];

    // behavioural reference state
    bit         m_busy, m_got;
    int         m_page, m_ofs, m_cnt, m_end;
    bit         m_valid [32];
    logic [7:0] m_buf   [32];

    always #10 clk = ~clk;

    pwb_commit u_dut (
        .clk(clk), .rst_n(rst_n), .cycle_len(cycle_len), .prot_mode(prot_mode),
        .wp(wp), .addr_load(addr_load), .start_addr(start_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .stop_stb(stop_stb),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .ptr_addr(ptr_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit locked(input int a);
        return wp && (!prot_mode || a >= 'h1800);
    endfunction

    always @(posedge clk) begin : mdl
        bit go;
        if (!rst_n) begin
            m_busy = 0; m_got = 0; m_page = 0; m_ofs = 0; m_cnt = 0; m_end = 32;
            for (int i = 0; i < 32; i++) begin m_valid[i] = 0; m_buf[i] = 0; end
        end else if (m_busy) begin
            if (m_cnt == m_end - 1) begin
                m_busy = 0; m_cnt = 0; m_got = 0;
                for (int i = 0; i < 32; i++) m_valid[i] = 0;
            end else begin
                m_cnt++;
            end
        end else begin
            go = stop_stb && m_got;
            if (addr_load) begin
                m_page = int'(start_addr) / 32;
                m_ofs  = int'(start_addr) % 32;
                m_got  = 0;
                for (int i = 0; i < 32; i++) m_valid[i] = 0;
            end else if (byte_stb) begin
                m_buf[m_ofs]   = byte_data;
                m_valid[m_ofs] = !locked(m_page * 32 + m_ofs);
                m_ofs = (m_ofs + 1) % 32;
                m_got = 1;
            end
            if (go) begin
                m_busy = 1; m_cnt = 0;
                m_end = (int'(cycle_len) < 32) ? 32 : int'(cycle_len);
            end
        end
    end

    always @(negedge clk) begin : cmp
        bit ew;
        if (rst_n) begin
            ew = m_busy && m_cnt < 32 && m_valid[m_cnt % 32];
            chk(busy == m_busy, "R5 busy vs model", busy, m_busy);
            chk(arr_we == ew, "R6 arr_we vs model", arr_we, ew);
            if (ew) begin
                chk(int'(arr_addr) == m_page * 32 + m_cnt, "R6 arr_addr", arr_addr, m_page * 32 + m_cnt);
                chk(arr_wdata == m_buf[m_cnt], "R6 arr_wdata", arr_wdata, m_buf[m_cnt]);
            end
            chk(int'(ptr_addr) == m_page * 32 + m_ofs, "R2 ptr_addr vs model", ptr_addr, m_page * 32 + m_ofs);
            if (arr_we) begin
                img[arr_addr] = arr_wdata;
                wcnt[arr_addr]++;
                total_w++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; errors++;
            $display("FAIL R5 watchdog actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input bit ld, input logic [12:0] a, input bit bs,
                        input logic [7:0] d, input bit sp);
        @(posedge clk); #2;
        addr_load = ld; start_addr = a; byte_stb = bs; byte_data = d; stop_stb = sp;
    endtask

    task automatic idle_run(output int n);
        n = 0;
        for (int k = 0; k < 3000; k++) begin
            step(0, 0, 0, 0, 0);
            @(negedge clk);
            if (busy) n++;
            else break;
        end
    endtask

    int n, w0;

    initial begin
        for (int i = 0; i < 8192; i++) begin img[i] = 8'h00; wcnt[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 0, "R1 reset busy", busy, 0);
        chk(arr_we == 0, "R1 reset arr_we", arr_we, 0);
        chk(ptr_addr == 0, "R1 reset ptr_addr", ptr_addr, 0);
        @(posedge clk); #2; rst_n = 1'b1;

        // basic transfer, page 9 slot 3
        cycle_len = 20'd40;
        w0 = total_w;
        step(1, 13'h0123, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 8'hA0 + 8'(i), 0);
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        chk(ptr_addr == 13'h0127, "R2 pointer after 4 bytes", ptr_addr, 'h127);
        step(0, 0, 0, 0, 1);
        idle_run(n);
        chk(n == 40, "R5 busy length 40", n, 40);
        chk(total_w - w0 == 4, "R6 write count", total_w - w0, 4);
        for (int i = 0; i < 4; i++)
            chk(img['h123 + i] == 8'hA0 + 8'(i), "R6 written data", img['h123 + i], 'hA0 + i);
        chk(ptr_addr == 13'h0127, "R10 pointer after commit", ptr_addr, 'h127);

        // wrap and overwrite: 34 bytes from slot 30 of page 5
        cycle_len = 20'd10;
        w0 = total_w;
        step(1, 13'h00BE, 0, 0, 0);
        for (int i = 0; i < 34; i++) step(0, 0, 1, 8'h40 + 8'(i), 0);
        step(0, 0, 0, 0, 1);
        idle_run(n);
        chk(n == 32, "R5 short cycle_len gives 32", n, 32);
        chk(total_w - w0 == 32, "R3 write count full page", total_w - w0, 32);
        for (int k = 0; k < 30; k++)
            chk(img['hA0 + k] == 8'h42 + 8'(k), "R3 wrapped slot", img['hA0 + k], 'h42 + k);
        chk(img['hBE] == 8'h60, "R3 overwritten slot 30", img['hBE], 'h60);
        chk(img['hBF] == 8'h61, "R3 overwritten slot 31", img['hBF], 'h61);
        chk(ptr_addr == 13'h00A0, "R3 pointer wrapped in page", ptr_addr, 'hA0);

        // stop without data
        step(0, 0, 0, 0, 1);
        idle_run(n);
        chk(n == 0, "R4 stop after commit no busy", n, 0);
        step(1, 13'h0200, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        idle_run(n);
        chk(n == 0, "R4 stop after load no busy", n, 0);

        // load and byte together: load wins
        step(1, 13'h0240, 1, 8'hEE, 0);
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        chk(ptr_addr == 13'h0240, "R11 load beats byte", ptr_addr, 'h240);
        step(0, 0, 0, 0, 1);
        idle_run(n);
        chk(n == 0, "R11 dropped byte arms nothing", n, 0);

        // stimulus during busy is ignored
        w0 = total_w;
        step(1, 13'h0300, 0, 0, 0);
        step(0, 0, 1, 8'h11, 0);
        step(0, 0, 1, 8'h22, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 1, 8'h77, 0);
        step(1, 13'h1000, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 1, 8'h78, 0);
        idle_run(n);
        chk(ptr_addr == 13'h0302, "R7 pointer untouched in busy", ptr_addr, 'h302);
        chk(wcnt['h302] == 0, "R7 ignored byte not written", wcnt['h302], 0);
        chk(wcnt['h1000] == 0, "R7 ignored load not written", wcnt['h1000], 0);
        chk(total_w - w0 == 2, "R7 only two writes", total_w - w0, 2);
        idle_run(n);
        chk(n == 0, "R7 ignored stop left no cycle", n, 0);

        // protection
        @(posedge clk); #2; wp = 1'b1; prot_mode = 1'b0;
        w0 = total_w;
        step(1, 13'h0400, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 8'h90 + 8'(i), 0);
        step(0, 0, 0, 0, 1);
        idle_run(n);
        chk(n == 32, "R8 protected transfer still busy", n, 32);
        chk(total_w - w0 == 0, "R8 whole array protected", total_w - w0, 0);

        @(posedge clk); #2; prot_mode = 1'b1;
        w0 = total_w;
        step(1, 13'h17FE, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 8'hC0 + 8'(i), 0);
        step(0, 0, 0, 0, 1);
        idle_run(n);
        chk(total_w - w0 == 4, "R8 below top quarter written", total_w - w0, 4);
        chk(img['h17E1] == 8'hC3, "R8 wrapped slot below quarter", img['h17E1], 'hC3);
        w0 = total_w;
        step(1, 13'h1805, 0, 0, 0);
        step(0, 0, 1, 8'hD0, 0);
        step(0, 0, 1, 8'hD1, 0);
        step(0, 0, 0, 0, 1);
        idle_run(n);
        chk(n == 32, "R8 top quarter still busy", n, 32);
        chk(total_w - w0 == 0, "R8 top quarter protected", total_w - w0, 0);
        chk(ptr_addr == 13'h1807, "R8 pointer advances past protected", ptr_addr, 'h1807);

        @(posedge clk); #2; wp = 1'b0;
        w0 = total_w;
        step(1, 13'h1F00, 0, 0, 0);
        step(0, 0, 1, 8'h3C, 0);
        step(0, 0, 0, 0, 1);
        idle_run(n);
        chk(total_w - w0 == 1, "R8 wp low unprotected", total_w - w0, 1);
        chk(img['h1F00] == 8'h3C, "R8 wp low data", img['h1F00], 'h3C);

        // flags cleared between transfers on the same page
        w0 = total_w;
        step(1, 13'h0130, 0, 0, 0);
        step(0, 0, 1, 8'h5A, 0);
        step(0, 0, 0, 0, 1);
        idle_run(n);
        chk(total_w - w0 == 1, "R9 only new slot written", total_w - w0, 1);
        chk(wcnt['h123] == 1, "R9 old slot not rewritten", wcnt['h123], 1);
        chk(img['h130] == 8'h5A, "R9 new data", img['h130], 'h5A);
        chk(ptr_addr == 13'h0131, "R10 pointer last plus one", ptr_addr, 'h131);

        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule